// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the command interface of a byte-wide NOR flash device. It sits in the system clock domain and samples an asynchronous-style memory bus made of chip enable, write enable, output enable, address and data. It treats every rising edge of write enable, seen while chip enable is low, as one bus write cycle. Commands take effect only after a strict two-write unlock prefix. The block then runs byte program, chip erase or sector erase as an embedded operation, and drives a ready/busy output while it runs. A sector erase can be suspended. While it is suspended, other sectors can be read and programmed, and the sector being erased keeps its contents until the erase is resumed.

The array is a small register file with 2^SEC_W sectors of 2^OFF_W bytes each. The sector comes from the top SEC_W address bits and the byte from the low OFF_W bits. Program and erase durations are set by cycle-count parameters. A parameter mask marks protected sectors, and the autoselect mode reports the protection of each sector together with a manufacturer code and a device code.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A program command lands in the array after PROG_CYC cycles as the old byte ANDed with the written data, so program only ever clears bits. The command is four writes: AAh to address 555h, 55h to 2AAh, A0h to 555h, then the target address with the data. While the program runs, a read returns bit 7 of the data inverted in bit 7 and zeros in bits 6:0.
- R2: The two unlock addresses are compared over the full address bus. Erased bytes read FFh.
- R3: A write that breaks the expected unlock or command sequence sends the decoder back to idle, so the next write starts a fresh sequence.
- R4: ry_by goes low in the cycle after the write-enable rising edge of the final command write. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R5: Chip erase is six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. It sets every byte of every unprotected sector to FFh.
- R6: Sector erase is the same six writes, except that the last one writes 30h to any address whose top SEC_W bits select the sector. It sets that sector to FFh and leaves every other sector unchanged.
- R7: Writing B0h during a sector erase suspends it, and ry_by is high in the next cycle. While suspended, the erasing sector reads its old contents, programs to other sectors complete, programs to the erasing sector are ignored, and writing 30h resumes the erase. A chip erase cannot be suspended.
- R8: Writing 90h as the third command write enters autoselect. In autoselect, address bits [1:0] = 0 read MFR_ID, 1 reads DEV_ID, and 2 reads 01h if the addressed sector is protected and 00h if it is not.
- R9: Writing F0h while no embedded operation is running leaves autoselect and abandons any partial sequence.
- R10: While reset_n is low, the decoder returns to idle and aborts any embedded operation without changing the array. If an operation was running, ry_by stays low while reset_n is low and for RECOV cycles after it is released. If no operation was running, ry_by stays high.
- R11: A program to a protected sector, or a sector erase of one, is ignored, and ry_by stays high.
- R12: Writes during a program, and writes other than the suspend command during an erase, are ignored.
- R13: dout_oe is high only when ce_n and oe_n are low and we_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Power-on reset, active low, asynchronous; fills the array with FFh |
| reset_n | input | 1 | Device reset input, active low, sampled on clk |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data: array byte, autoselect code or status |
| dout_oe | output | 1 | High when dout should drive the bus |
| ry_by | output | 1 | Ready (1) or busy (0) |

## Verification
Two pairs of functions can fall on the same clock edge. A device reset can arrive while the program counter is still running, and a suspend command can land on an edge where the erase counter would otherwise decrement. The bench drops reset_n two cycles into a program. It then checks that the busy time after release equals RECOV exactly and that the target byte still holds its old value. It suspends a sector erase partway through, reads and programs neighbouring sectors while suspended, and resumes the erase. After the resume it requires a remaining busy time strictly between zero and ERASE_CYC, and the erased sector reading all FFh.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 19,
  parameter int SEC_W = 3,
  parameter int OFF_W = 2,
  parameter int PROG_CYC = 6,
  parameter int ERASE_CYC = 40,
  parameter int RECOV = 5,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'hB5,
  parameter logic [(1<<SEC_W)-1:0] PROT_MASK = 1
) (
  input  logic          clk,
  input  logic          sys_rst_n,
  input  logic          reset_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_oe,
  output logic          ry_by
);
  localparam int NSEC = 1 << SEC_W;
  localparam int IW = SEC_W + OFF_W;
  localparam int DEPTH = 1 << IW;
  localparam int CW = $clog2(ERASE_CYC + PROG_CYC + RECOV + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3} seq_t;
  typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_ERASE, OP_SUSP, OP_SPROG} op_t;

  logic [7:0]      mem [DEPTH];
  seq_t            seq;
  op_t             op;
  logic            autosel, chip, we_q;
  logic [NSEC-1:0] emask;
  logic [CW-1:0]   pcnt, ecnt, rcnt;
  logic [IW-1:0]   pidx;
  logic [7:0]      pdata;

  wire             wr_ev = ~we_q & we_n & ~ce_n;
  wire             is555 = addr == AW'(12'h555);
  wire             is2aa = addr == AW'(12'h2AA);
  wire [SEC_W-1:0] sec = addr[AW-1 -: SEC_W];
  wire [IW-1:0]    idx = {sec, addr[OFF_W-1:0]};
  wire             prot = PROT_MASK[sec];
  wire             rec = rcnt != '0;
  wire             prog_busy = (op == OP_PROG) || (op == OP_SPROG);
  wire             take = wr_ev & reset_n & ~rec;
  wire             prog_done = prog_busy && pcnt == CW'(1) && reset_n;
  wire             erase_done = op == OP_ERASE && ecnt == CW'(1) && reset_n;
  wire             susp_req = take && op == OP_ERASE && !chip && din == 8'hB0 && !erase_done;
  wire             cmd_ok = take && (op == OP_NONE || op == OP_SUSP);

  assign ry_by = !(prog_busy || op == OP_ERASE || rec);
  assign dout_oe = ~ce_n & ~oe_n & we_n;

  always_comb begin
    if (prog_busy) dout = {~pdata[7], 7'b0};
    else if (op == OP_ERASE || rec) dout = 8'h00;
    else if (autosel) begin
      case (addr[1:0])
        2'd0:    dout = MFR_ID;
        2'd1:    dout = DEV_ID;
        2'd2:    dout = {7'b0, prot};
        default: dout = 8'h00;
      endcase
    end else dout = mem[idx];
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_done) begin
      mem[pidx] <= mem[pidx] & pdata;
    end else if (erase_done) begin
      for (int i = 0; i < DEPTH; i++)
        if (emask[SEC_W'(i >> OFF_W)]) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      seq <= S_IDLE; op <= OP_NONE; autosel <= 1'b0; chip <= 1'b0; we_q <= 1'b1;
      emask <= '0; pcnt <= '0; ecnt <= '0; rcnt <= '0; pidx <= '0; pdata <= 8'hFF;
    end else begin
      we_q <= we_n;
      if (!reset_n) begin
        seq <= S_IDLE; op <= OP_NONE; autosel <= 1'b0; chip <= 1'b0;
        emask <= '0; pcnt <= '0; ecnt <= '0;
        rcnt <= ry_by ? '0 : CW'(RECOV);
      end else begin
        if (rec) rcnt <= rcnt - 1'b1;
        if (prog_busy) begin
          pcnt <= pcnt - 1'b1;
          if (prog_done) op <= (op == OP_SPROG) ? OP_SUSP : OP_NONE;
        end
        if (op == OP_ERASE) begin
          if (erase_done) begin
            op <= OP_NONE; emask <= '0; chip <= 1'b0;
          end else if (susp_req) op <= OP_SUSP;
          else ecnt <= ecnt - 1'b1;
        end
        if (cmd_ok) begin
          if (din == 8'hF0) begin
            seq <= S_IDLE; autosel <= 1'b0;
          end else if (op == OP_SUSP && seq == S_IDLE && din == 8'h30) begin
            op <= OP_ERASE;
          end else begin
            case (seq)
              S_IDLE: seq <= (is555 && din == 8'hAA) ? S_U1 : S_IDLE;
              S_U1:   seq <= (is2aa && din == 8'h55) ? S_U2 : S_IDLE;
              S_U2: begin
                seq <= S_IDLE;
                if (is555) begin
                  case (din)
                    8'hA0: seq <= S_PROG;
                    8'h90: autosel <= 1'b1;
                    8'h80: if (op == OP_NONE) seq <= S_E1;
                    default: ;
                  endcase
                end
              end
              S_PROG: begin
                seq <= S_IDLE; autosel <= 1'b0;
                if (!prot && !(op == OP_SUSP && emask[sec])) begin
                  op <= (op == OP_SUSP) ? OP_SPROG : OP_PROG;
                  pcnt <= CW'(PROG_CYC); pidx <= idx; pdata <= din;
                end
              end
              S_E1: seq <= (is555 && din == 8'hAA) ? S_E2 : S_IDLE;
              S_E2: seq <= (is2aa && din == 8'h55) ? S_E3 : S_IDLE;
              S_E3: begin
                seq <= S_IDLE; autosel <= 1'b0;
                if (is555 && din == 8'h10) begin
                  op <= OP_ERASE; chip <= 1'b1; emask <= ~PROT_MASK; ecnt <= CW'(ERASE_CYC);
                end else if (din == 8'h30 && !prot) begin
                  op <= OP_ERASE; chip <= 1'b0; ecnt <= CW'(ERASE_CYC);
                  emask <= {{(NSEC-1){1'b0}}, 1'b1} << sec;
                end
              end
              default: seq <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  p_busy_cause_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(ry_by) |-> $past(wr_ev));
  p_susp_ready_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    susp_req |=> ry_by);
  p_reset_hold_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!reset_n && !ry_by) |=> !ry_by);
  p_and_only_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    prog_done |=> (mem[pidx] & ~$past(mem[pidx])) == 8'h00);
  p_prot_kept_r11: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (emask & PROT_MASK) == '0);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_P = 10;
  localparam int PROG_CYC = 4;
  localparam int ERASE_CYC = 20;
  localparam int RECOV = 3;
  localparam logic [7:0] MFR = 8'h3C;
  localparam logic [7:0] DEV = 8'hA7;

  logic clk = 1'b0, sys_rst_n = 1'b0, reset_n = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe, ry_by;
  int nchk = 0, nfail = 0;
  logic [7:0] exp_mem [32];

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_decoder #(.AW(19), .SEC_W(3), .OFF_W(2), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .RECOV(RECOV), .MFR_ID(MFR), .DEV_ID(DEV),
    .PROT_MASK(8'h01)) u_flash_cmd_decoder (
    .clk(clk), .sys_rst_n(sys_rst_n), .reset_n(reset_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .ry_by(ry_by));

  function automatic logic [18:0] at(input int s, input int o);
    return {3'(s), 14'h0, 2'(o)};
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [18:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    #1 d = dout;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ry_by && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic unlock();
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [18:0] a, input logic [7:0] d);
    unlock(); wr(19'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_cmd(input logic [18:0] a, input logic [7:0] d);
    unlock(); wr(19'h555, 8'h80); unlock(); wr(a, d);
  endtask

  task automatic check_all(input string r);
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      rd(at(i >> 2, i & 3), v);
      chk(r, v, exp_mem[i]);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    chk("reset ry_by R10", ry_by, 1);
    chk("reset dout_oe R13", dout_oe, 0);
    check_all("erased after reset R2");

    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; #1 chk("oe with we low R13", dout_oe, 0);
    we_n = 1'b1; #1 chk("oe read R13", dout_oe, 1);
    ce_n = 1'b1; #1 chk("oe ce high R13", dout_oe, 0);
    oe_n = 1'b1;

    unlock(); wr(19'h555, 8'h90);
    for (int s = 0; s < 8; s++) begin
      rd(at(s, 0), v); chk("autoselect mfr R8", v, MFR);
      rd(at(s, 1), v); chk("autoselect dev R8", v, DEV);
      rd(at(s, 2), v); chk("autoselect protect R8", v, (s == 0) ? 1 : 0);
    end
    wr(19'h0, 8'hF0);
    rd(at(2, 1), v); chk("F0 leaves autoselect R9", v, 8'hFF);

    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 32; i++) begin
        logic [7:0] d;
        d = (pass == 0) ? 8'(i * 29 + 7) : 8'(i * 53 + 145);
        prog(at(i >> 2, i & 3), d);
        if ((i >> 2) == 0) begin
          chk("protected program ignored R11", ry_by, 1);
        end else begin
          rd(at(i >> 2, i & 3), v);
          chk("status bit7 during program R1", v, {~d[7], 7'b0});
          wait_rdy(n);
          chk("program busy length R4", n + 1, PROG_CYC);
          exp_mem[i] = exp_mem[i] & d;
        end
      end
      check_all("program AND result R1");
    end

    unlock(); wr(19'h555, 8'h12); wr(at(4, 0), 8'h00);
    chk("bad command no busy R3", ry_by, 1);
    wr(19'h555, 8'hAA); wr(19'h2AB, 8'h55); wr(19'h555, 8'hA0); wr(at(4, 1), 8'h00);
    chk("bad unlock address R2", ry_by, 1);
    rd(at(4, 0), v); chk("bad command no program R3", v, exp_mem[16]);
    rd(at(4, 1), v); chk("bad unlock no program R2", v, exp_mem[17]);

    unlock(); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(at(4, 2), 8'h00);
    rd(at(4, 2), v); chk("partial sequence restart R3", v, exp_mem[18]);

    prog(at(5, 0), 8'h00);
    wr(19'h555, 8'hAA);
    wait_rdy(n);
    exp_mem[20] = 8'h00;
    wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(at(5, 1), 8'h00);
    chk("write during program ignored R12", ry_by, 1);
    rd(at(5, 1), v); chk("write during program ignored R12", v, exp_mem[21]);

    unlock(); wr(19'h2AA, 8'hF0); wr(19'h555, 8'hA0); wr(at(5, 2), 8'h00);
    rd(at(5, 2), v); chk("F0 abandons sequence R9", v, exp_mem[22]);

    erase_cmd(at(0, 3), 8'h30);
    chk("protected sector erase ignored R11", ry_by, 1);

    erase_cmd(at(3, 2), 8'h30);
    wait_rdy(n);
    chk("sector erase busy R4", n, ERASE_CYC);
    for (int o = 0; o < 4; o++) exp_mem[12 + o] = 8'hFF;
    check_all("sector erase R6");

    erase_cmd(at(5, 0), 8'h30);
    wr(at(1, 0), 8'h00);
    chk("other write during erase ignored R12", ry_by, 0);
    wr(19'h0, 8'hB0);
    chk("suspend ready R7", ry_by, 1);
    rd(at(5, 0), v); chk("suspended sector frozen R7", v, exp_mem[20]);
    rd(at(6, 1), v); chk("read other sector R7", v, exp_mem[25]);
    prog(at(6, 1), 8'h0F);
    wait_rdy(n);
    chk("program in suspend busy R7", n, PROG_CYC);
    exp_mem[25] = exp_mem[25] & 8'h0F;
    rd(at(6, 1), v); chk("program in suspend R7", v, exp_mem[25]);
    prog(at(5, 3), 8'h00);
    chk("program erasing sector ignored R7", ry_by, 1);
    rd(at(5, 3), v); chk("program erasing sector ignored R7", v, exp_mem[23]);
    wr(19'h0, 8'h30);
    chk("resume busy R7", ry_by, 0);
    wait_rdy(n);
    chk("resume remaining R7", (n > 0 && n < ERASE_CYC) ? 1 : 0, 1);
    for (int o = 0; o < 4; o++) exp_mem[20 + o] = 8'hFF;
    check_all("erase after resume R7");

    for (int s = 0; s < 8; s++) prog(at(s, 0), 8'(s * 17));
    for (int s = 0; s < 8; s++) if (s != 0) exp_mem[s * 4] = exp_mem[s * 4] & 8'(s * 17);
    wait_rdy(n);
    erase_cmd(19'h555, 8'h10);
    wr(19'h0, 8'hB0);
    chk("chip erase not suspendable R7", ry_by, 0);
    wait_rdy(n);
    chk("chip erase busy R4", n + 3, ERASE_CYC);
    for (int i = 4; i < 32; i++) exp_mem[i] = 8'hFF;
    check_all("chip erase R5");

    prog(at(2, 1), 8'h00);
    @(negedge clk); reset_n = 1'b0;
    @(negedge clk); chk("busy during reset R10", ry_by, 0);
    @(negedge clk); reset_n = 1'b1;
    wait_rdy(n);
    chk("recovery length R10", n, RECOV);
    rd(at(2, 1), v); chk("aborted program R10", v, exp_mem[9]);
    @(negedge clk); reset_n = 1'b0;
    @(negedge clk); chk("idle reset ready R10", ry_by, 1);
    reset_n = 1'b1;
    @(negedge clk); chk("idle reset ready R10", ry_by, 1);

    finish_run();
  end
endmodule